// File: doc/BRIEF.md
# Radix-4 Butterfly Systolic Array

This block multiplies a 4 x 4 coefficient matrix C by a stream of complex data columns, producing Y = C·X one column at a time. Every coefficient is one of 1, -1, j or -j. Because of this, each processing element builds its product by swapping and negating the real and imaginary parts of the incoming sample. It then adds the result into a running partial sum using two real adders and no multiplier. A data column enters on four lanes. Row j of the array sees its lane j cycles late. Partial sums move down the array and samples move to the right, so output lane i comes out of the bottom edge i cycles after lane 0.

Coefficients arrive through a shift port. Each push carries one column of C and enters at the bottom slot of a shadow bank, while older pushes move toward slot 0. A small controller tracks how full the shadow bank is, in four named states:

- SH_EMPTY: no rows loaded since reset.
- SH_FILL: fewer than four rows loaded.
- SH_FULL: four or more rows loaded.
- SH_DRAIN: seven cycles after an accepted commit.

The transitions are:

- SH_EMPTY to SH_FILL on a shift.
- SH_FILL to SH_FULL on the fourth shift.
- SH_FULL to SH_FULL on a shift.
- SH_FULL to SH_DRAIN on a commit.
- SH_DRAIN to SH_FULL when its count ends.

An accepted commit is a token that travels through the array with the data column presented in the same cycle. Each element copies its shadow code into its active code just as that column passes. Columns already inside the array finish with the old matrix, and later columns use the new one.

Top module: `r4sa_array`

## Requirements
- R1: After reset every out_vld bit is low, the shadow bank is empty, and every active coefficient is code 00 (value 1), so each output lane gives the plain sum of the four input lanes.
- R2: For each valid column, output lane i equals the sum over j of C[i][j]·x[j]. The codes are 00 = 1, 01 = -j, 10 = -1 and 11 = j. Multiplying by -j maps (a,b) to (b,-a), and multiplying by j maps (a,b) to (-b,a). The result is exact in DW+3 bits.
- R3: A column presented with in_vld in cycle n gives out_vld[i] and the lane i result in cycle n+4+i. Lane m of every packed bus sits at bits [m*width +: width].
- R4: A new column may be presented on every cycle with no bubble. Gaps in in_vld appear unchanged in each out_vld lane, and the columns do not interact.
- R5: Each coef_shift cycle writes coef_row into shadow slot 3 and moves slot k+1 into slot k. Field [2i+1:2i] of a pushed word is C[i][j], where j is the slot the word sits in. After four shifts the first word pushed sits in slot 0.
- R6: The controller states and transitions are the ones listed above. A commit is accepted only in SH_FULL, and a commit in SH_EMPTY, SH_FILL or SH_DRAIN has no effect. SH_DRAIN lasts exactly 7 cycles and then returns to SH_FULL.
- R7: An accepted commit applies to the column presented in the same cycle and to every later column. Columns presented earlier keep the old matrix even while they are still inside the array.
- R8: coef_shift has no effect while the controller is in SH_DRAIN. It also has no effect in a cycle where a commit is accepted.
- R9: Full-scale inputs (-2^(DW-1) on every part) under any code mix give the exact result, including +4·2^(DW-1), with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Data column valid |
| in_commit | input | 1 | Request to make the shadow matrix active from this column on |
| in_re | input | LANES*DW | Real parts of the column, lane m at [m*DW +: DW] |
| in_im | input | LANES*DW | Imaginary parts of the column |
| coef_shift | input | 1 | Push coef_row into the shadow bank |
| coef_row | input | 2*LANES | One column of C, field i = code of C[i][j] |
| out_vld | output | LANES | Per-lane result valid, skewed by lane |
| out_re | output | LANES*AW | Real results, AW = DW+3, lane i at [i*AW +: AW] |
| out_im | output | LANES*AW | Imaginary results |

## Verification
A stale or wrong active code in element (j,i) corrupts only output lane i, starting 4+i cycles after the first column that reaches that element. The error repeats on every later column until the next commit passes. A controller stuck in the wrong state shows up as a commit that is honoured or ignored against the rules. Within 4 to 7 cycles, the following columns then come out with the wrong matrix. A stray shadow shift shows up at the next commit. A skew or valid error shows up as out_vld lanes that no longer trail each other by exactly one cycle. The reference model recomputes every lane every cycle, so each of these faults is reported in the first cycle it reaches a port.

// File: rtl/r4sa_pkg.sv
package r4sa_pkg;

    // Coefficient codes; bit 1 flips the sign, bit 0 swaps real/imaginary.
    typedef enum logic [1:0] {
        CODE_POS1 = 2'b00,
        CODE_NEGJ = 2'b01,
        CODE_NEG1 = 2'b10,
        CODE_POSJ = 2'b11
    } coef_code_e;

    typedef enum logic [1:0] {
        SH_EMPTY,
        SH_FILL,
        SH_FULL,
        SH_DRAIN
    } shadow_state_e;

endpackage

// File: rtl/r4sa_skew.sv
// Delay line: tap i carries the input delayed by LEAD+i register stages.
module r4sa_skew #(
    parameter int W    = 8,
    parameter int LEAD = 0,
    parameter int TAPS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] tap_o [TAPS]
);
    localparam int NSTG = LEAD + TAPS;

    logic [W-1:0] stg [NSTG];

    assign stg[0] = d_i;

    for (genvar k = 1; k < NSTG; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
        end
    end

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign tap_o[t] = stg[LEAD+t];
    end
endmodule

// File: rtl/r4sa_coef_ctrl.sv
module r4sa_coef_ctrl
    import r4sa_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              shift_i,
    input  logic [2*LANES-1:0]                row_i,
    input  logic                              commit_i,
    output logic                              commit_acc_o,
    output logic [LANES-1:0][2*LANES-1:0]     shadow_o
);
    localparam int DRAIN_LEN = 2*LANES - 1;
    localparam int FW        = $clog2(LANES + 1);
    localparam int DWID      = $clog2(DRAIN_LEN + 1);

    shadow_state_e                  state_q, state_d;
    logic [FW-1:0]                  fill_q, fill_d;
    logic [DWID-1:0]                drain_q, drain_d;
    logic [LANES-1:0][2*LANES-1:0]  shadow_q;
    logic                           shift_do;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SH_EMPTY;
            fill_q  <= '0;
            drain_q <= '0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
            drain_q <= drain_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        fill_d  = fill_q;
        drain_d = drain_q;
        unique case (state_q)
            SH_EMPTY: if (shift_i) begin
                state_d = SH_FILL;
                fill_d  = FW'(1);
            end
            SH_FILL: if (shift_i) begin
                fill_d = fill_q + FW'(1);
                if (fill_q == FW'(LANES-1)) state_d = SH_FULL;
            end
            SH_FULL: if (commit_i) begin
                state_d = SH_DRAIN;
                drain_d = '0;
            end
            SH_DRAIN: begin
                if (drain_q == DWID'(DRAIN_LEN-1)) state_d = SH_FULL;
                else                               drain_d = drain_q + DWID'(1);
            end
            default: state_d = SH_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        commit_acc_o = (state_q == SH_FULL) && commit_i;
        shift_do     = shift_i && (state_q != SH_DRAIN) && !commit_acc_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (shift_do) begin
            for (int k = 0; k < LANES-1; k++) shadow_q[k] <= shadow_q[k+1];
            shadow_q[LANES-1] <= row_i;
        end
    end

    assign shadow_o = shadow_q;

    // R8
    drain_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_DRAIN) |-> $stable(shadow_q));

    // R6
    full_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_FULL) |-> ($past(state_q) != SH_EMPTY));

    // R6
    commit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_acc_o |=> (state_q == SH_DRAIN));
endmodule

// File: rtl/r4sa_pe.sv
module r4sa_pe
    import r4sa_pkg::*;
#(
    parameter int DW  = 12,
    parameter int AW  = 15,
    parameter int ROW = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          x_vld_i,
    input  logic          x_cmt_i,
    input  logic [DW-1:0] x_re_i,
    input  logic [DW-1:0] x_im_i,
    input  logic [1:0]    shadow_code_i,
    input  logic          psum_vld_i,
    input  logic [AW-1:0] psum_re_i,
    input  logic [AW-1:0] psum_im_i,
    output logic          psum_vld_o,
    output logic [AW-1:0] psum_re_o,
    output logic [AW-1:0] psum_im_o
);
    localparam int LIM = (ROW + 1) * (2 ** (DW - 1));

    logic [1:0]           act_q, code_use;
    logic signed [AW-1:0] a_ext, b_ext, re_op, im_op;
    logic                 re_neg, im_neg;
    logic [AW-1:0]        psum_re_q, psum_im_q;
    logic                 psum_vld_q;

    assign a_ext    = AW'($signed(x_re_i));
    assign b_ext    = AW'($signed(x_im_i));
    assign code_use = x_cmt_i ? shadow_code_i : act_q;

    // Operand routing: swap and sign instead of a multiplier
    always_comb begin
        unique case (coef_code_e'(code_use))
            CODE_POS1: begin re_op = a_ext; re_neg = 1'b0; im_op = b_ext; im_neg = 1'b0; end
            CODE_NEGJ: begin re_op = b_ext; re_neg = 1'b0; im_op = a_ext; im_neg = 1'b1; end
            CODE_NEG1: begin re_op = a_ext; re_neg = 1'b1; im_op = b_ext; im_neg = 1'b1; end
            CODE_POSJ: begin re_op = b_ext; re_neg = 1'b1; im_op = a_ext; im_neg = 1'b0; end
            default:   begin re_op = a_ext; re_neg = 1'b0; im_op = b_ext; im_neg = 1'b0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q      <= 2'b00;
            psum_re_q  <= '0;
            psum_im_q  <= '0;
            psum_vld_q <= 1'b0;
        end else begin
            if (x_cmt_i) act_q <= shadow_code_i;
            psum_re_q  <= re_neg ? psum_re_i - re_op : psum_re_i + re_op;
            psum_im_q  <= im_neg ? psum_im_i - im_op : psum_im_i + im_op;
            psum_vld_q <= psum_vld_i & x_vld_i;
        end
    end

    assign psum_re_o  = psum_re_q;
    assign psum_im_o  = psum_im_q;
    assign psum_vld_o = psum_vld_q;

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(psum_re_q) <= LIM) && ($signed(psum_re_q) >= -LIM) &&
        ($signed(psum_im_q) <= LIM) && ($signed(psum_im_q) >= -LIM));
endmodule

// File: rtl/r4sa_array.sv
module r4sa_array
    import r4sa_pkg::*;
#(
    parameter  int DW    = 12,
    parameter  int LANES = 4,
    localparam int AW    = DW + $clog2(LANES) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_vld,
    input  logic                  in_commit,
    input  logic [LANES*DW-1:0]   in_re,
    input  logic [LANES*DW-1:0]   in_im,
    input  logic                  coef_shift,
    input  logic [2*LANES-1:0]    coef_row,
    output logic [LANES-1:0]      out_vld,
    output logic [LANES*AW-1:0]   out_re,
    output logic [LANES*AW-1:0]   out_im
);
    localparam int BW = 2 + 2*DW;

    logic                            commit_acc;
    logic [LANES-1:0][2*LANES-1:0]   shadow_rows;
    logic [AW-1:0]                   ps_re  [LANES+1][LANES];
    logic [AW-1:0]                   ps_im  [LANES+1][LANES];
    logic                            ps_vld [LANES+1][LANES];

    r4sa_coef_ctrl #(.LANES(LANES)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .shift_i      (coef_shift),
        .row_i        (coef_row),
        .commit_i     (in_commit),
        .commit_acc_o (commit_acc),
        .shadow_o     (shadow_rows)
    );

    for (genvar c = 0; c < LANES; c++) begin : g_top
        assign ps_re[0][c]  = '0;
        assign ps_im[0][c]  = '0;
        assign ps_vld[0][c] = 1'b1;
        assign out_re[c*AW +: AW] = ps_re[LANES][c];
        assign out_im[c*AW +: AW] = ps_im[LANES][c];
        assign out_vld[c]         = ps_vld[LANES][c];
    end

    for (genvar j = 0; j < LANES; j++) begin : g_row
        logic [BW-1:0] row_taps [LANES];

        r4sa_skew #(.W(BW), .LEAD(j), .TAPS(LANES)) u_skew (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   ({in_vld, commit_acc, in_re[j*DW +: DW], in_im[j*DW +: DW]}),
            .tap_o (row_taps)
        );

        for (genvar i = 0; i < LANES; i++) begin : g_col
            r4sa_pe #(.DW(DW), .AW(AW), .ROW(j)) u_pe (
                .clk           (clk),
                .rst_n         (rst_n),
                .x_vld_i       (row_taps[i][BW-1]),
                .x_cmt_i       (row_taps[i][BW-2]),
                .x_re_i        (row_taps[i][2*DW-1:DW]),
                .x_im_i        (row_taps[i][DW-1:0]),
                .shadow_code_i (shadow_rows[j][2*i +: 2]),
                .psum_vld_i    (ps_vld[j][i]),
                .psum_re_i     (ps_re[j][i]),
                .psum_im_i     (ps_im[j][i]),
                .psum_vld_o    (ps_vld[j+1][i]),
                .psum_re_o     (ps_re[j+1][i]),
                .psum_im_o     (ps_im[j+1][i])
            );
        end
    end

    for (genvar c = 1; c < LANES; c++) begin : g_skew_chk
        // R3
        lane_skew_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld[c] == $past(out_vld[c-1]));
    end
endmodule

// File: tb/r4sa_array_tb.sv
`timescale 1ns/1ps
module r4sa_array_tb;
    localparam int DW   = 12;
    localparam int L    = 4;
    localparam int AW   = DW + 3;
    localparam int NCYC = 4096;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n;
    logic              in_vld, in_commit, coef_shift;
    logic [L*DW-1:0]   in_re, in_im;
    logic [2*L-1:0]    coef_row;
    logic [L-1:0]      out_vld;
    logic [L*AW-1:0]   out_re, out_im;

    r4sa_array #(.DW(DW), .LANES(L)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_commit(in_commit),
        .in_re(in_re), .in_im(in_im), .coef_shift(coef_shift), .coef_row(coef_row),
        .out_vld(out_vld), .out_re(out_re), .out_im(out_im)
    );

    int    exp_v [NCYC][L];
    int    exp_r [NCYC][L];
    int    exp_i [NCYC][L];
    string exp_tag [NCYC][L];

    int sh  [L][L];   // shadow model: sh[slot j][field i]
    int act [L][L];   // active matrix: act[i][j]
    int fill, drain_left, cyc;
    int compared, mismatched;
    bit done;
    string cur_tag;

    bit             d_vld, d_cmt, d_sft;
    logic [2*L-1:0] d_row;
    int             d_xr [L];
    int             d_xi [L];

    function automatic void cmul(input int code, input int a, input int b,
                                 output int r, output int im);
        case (code)
            0:       begin r = a;  im = b;  end
            1:       begin r = b;  im = -a; end
            2:       begin r = -a; im = -b; end
            default: begin r = -b; im = a;  end
        endcase
    endfunction

    task automatic check_outputs();
        for (int l = 0; l < L; l++) begin
            string tg;
            int gr, gi;
            tg = (exp_tag[cyc][l] == "") ? "R1" : exp_tag[cyc][l];
            compared++;
            if (int'(out_vld[l]) != exp_v[cyc][l]) begin
                mismatched++;
                $display("FAIL %s cycle %0d lane %0d valid: got %0d expected %0d",
                         tg, cyc, l, out_vld[l], exp_v[cyc][l]);
            end
            if (exp_v[cyc][l] != 0) begin
                gr = int'($signed(out_re[l*AW +: AW]));
                gi = int'($signed(out_im[l*AW +: AW]));
                compared++;
                if (gr != exp_r[cyc][l] || gi != exp_i[cyc][l]) begin
                    mismatched++;
                    $display("FAIL %s cycle %0d lane %0d data: got (%0d,%0d) expected (%0d,%0d)",
                             tg, cyc, l, gr, gi, exp_r[cyc][l], exp_i[cyc][l]);
                end
            end
        end
    endtask

    task automatic model();
        bit in_drain, acc;
        in_drain = (drain_left > 0);
        acc      = d_cmt && (fill >= L) && !in_drain;
        if (acc) begin
            for (int i = 0; i < L; i++)
                for (int j = 0; j < L; j++) act[i][j] = sh[j][i];
        end else if (d_sft && !in_drain) begin
            for (int j = 0; j < L-1; j++)
                for (int i = 0; i < L; i++) sh[j][i] = sh[j+1][i];
            for (int i = 0; i < L; i++) sh[L-1][i] = int'(d_row[2*i +: 2]);
            if (fill < L) fill++;
        end
        if (d_vld) begin
            for (int i = 0; i < L; i++) begin
                int sr, si, pr, pi;
                sr = 0; si = 0;
                for (int j = 0; j < L; j++) begin
                    cmul(act[i][j], d_xr[j], d_xi[j], pr, pi);
                    sr += pr; si += pi;
                end
                if (cyc + 4 + i < NCYC) begin
                    exp_v[cyc+4+i][i]   = 1;
                    exp_r[cyc+4+i][i]   = sr;
                    exp_i[cyc+4+i][i]   = si;
                    exp_tag[cyc+4+i][i] = cur_tag;
                end
            end
        end
        if (in_drain) drain_left--;
        if (acc) drain_left = 2*L - 1;
    endtask

    task automatic step();
        @(negedge clk);
        check_outputs();
        in_vld     = d_vld;
        in_commit  = d_cmt;
        coef_shift = d_sft;
        coef_row   = d_row;
        for (int l = 0; l < L; l++) begin
            in_re[l*DW +: DW] = d_xr[l][DW-1:0];
            in_im[l*DW +: DW] = d_xi[l][DW-1:0];
        end
        model();
        cyc++;
    endtask

    task automatic rand_col();
        for (int l = 0; l < L; l++) begin
            d_xr[l] = int'($urandom_range(4095)) - 2048;
            d_xi[l] = int'($urandom_range(4095)) - 2048;
        end
    endtask

    task automatic quiet();
        d_vld = 0; d_cmt = 0; d_sft = 0; d_row = '0;
    endtask

    task automatic idle(input int n);
        quiet();
        repeat (n) step();
    endtask

    task automatic data_run(input int n);
        quiet();
        for (int k = 0; k < n; k++) begin
            d_vld = 1'b1; rand_col(); step();
        end
    endtask

    function automatic logic [2*L-1:0] dft_word(input int j);
        logic [2*L-1:0] w;
        for (int i = 0; i < L; i++) w[2*i +: 2] = 2'((i * j) % 4);
        return w;
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        rst_n = 0; in_vld = 0; in_commit = 0; coef_shift = 0; coef_row = '0;
        in_re = '0; in_im = '0;
        cyc = 0; compared = 0; mismatched = 0; fill = 0; drain_left = 0; done = 0;
        for (int a = 0; a < L; a++)
            for (int b = 0; b < L; b++) begin sh[a][b] = 0; act[a][b] = 0; end
        for (int l = 0; l < L; l++) begin d_xr[l] = 0; d_xi[l] = 0; end
        quiet();
        repeat (5) @(negedge clk);
        rst_n = 1;

        // R1: idle after reset, then the default all-ones matrix
        cur_tag = "R1";
        idle(6);
        data_run(6);
        idle(6);

        // R6: commit while the shadow bank is empty is ignored
        cur_tag = "R6";
        d_vld = 1; d_cmt = 1; rand_col(); step();
        quiet(); data_run(3);

        // R5: push DFT columns; commit during fill is ignored (R6)
        cur_tag = "R5";
        for (int j = 0; j < L; j++) begin
            quiet(); d_sft = 1; d_row = dft_word(j); d_vld = 1; rand_col();
            if (j == 2) d_cmt = 1;
            step();
        end

        // R7: column before commit keeps the old matrix, commit column gets the new one
        cur_tag = "R7";
        quiet(); d_vld = 1; rand_col(); step();
        d_cmt = 1; rand_col(); step();
        quiet();

        // R8: shifts during drain and a commit during drain have no effect
        cur_tag = "R8";
        for (int k = 0; k < 2*L - 1; k++) begin
            quiet(); d_vld = 1; rand_col(); d_sft = 1; d_row = 8'($urandom_range(255));
            if (k == 2) d_cmt = 1;
            step();
        end
        quiet(); d_vld = 1; d_cmt = 1; rand_col(); step();
        quiet(); data_run(8);

        // R8: commit together with shift in SH_FULL drops the shift
        quiet(); d_cmt = 1; d_sft = 1; d_row = 8'hE4; d_vld = 1; rand_col(); step();
        quiet(); data_run(8);
        quiet(); d_cmt = 1; d_vld = 1; rand_col(); step();

        // R2: DFT matrix applied to a back-to-back block
        cur_tag = "R2";
        data_run(12);

        // R4: new random matrix with a gappy back-to-back stream
        cur_tag = "R4";
        for (int j = 0; j < L; j++) begin
            quiet(); d_sft = 1; d_row = 8'($urandom_range(255)); step();
        end
        quiet(); d_cmt = 1; d_vld = 1; rand_col(); step();
        for (int k = 0; k < 40; k++) begin
            quiet(); d_vld = (k % 5 != 3) && (k % 7 != 6); rand_col(); step();
        end

        // R3: isolated single columns to pin the latency per lane
        cur_tag = "R3";
        idle(9);
        data_run(1);
        idle(9);

        // R9: full-scale inputs under negate and swap codes
        cur_tag = "R9";
        for (int j = 0; j < L; j++) begin
            quiet(); d_sft = 1; d_row = 8'b01_10_10_10; step();
        end
        idle(8);
        quiet(); d_cmt = 1; d_vld = 1;
        for (int l = 0; l < L; l++) begin d_xr[l] = -2048; d_xi[l] = -2048; end
        step();
        quiet(); d_vld = 1;
        for (int l = 0; l < L; l++) begin d_xr[l] = 2047; d_xi[l] = -2048; end
        step();
        quiet(); d_vld = 1;
        for (int l = 0; l < L; l++) begin d_xr[l] = -2048; d_xi[l] = 2047; end
        step();

        idle(12);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog (R1-wide run hang): got no completion, expected completion");
            summary();
            $finish;
        end
    end
endmodule